// File: doc/BRIEF.md
# Video RAM serial port controller

This block is the serial side of a dual-port video memory. It holds a static data register with one entry per column. A transfer cycle either fills the register from one row of the memory array or writes the register back to a row. After each transfer, the register is read or written one entry at a time on a serial clock. The memory array itself sits outside the block. The block reaches it through a row interface that loads or stores a whole row in one step.

All strobes are level inputs, sampled on the system clock, and the block detects their edges. On the falling edge of the row strobe, with the transfer gate low, the block latches the transfer kind, the row, the tap column and the special function select. The transfer takes effect on the rising edge of the row strobe. That step moves the data, sets the serial direction, loads the serial pointer with the tap, and updates the half indicator.

Each rising edge of the serial clock moves the pointer up by one entry. The pointer wraps from the last entry back to the first. In output mode the entry under the pointer is driven out. In input mode the serial data pins are written into the entry under the pointer, but only while serial enable is asserted. `DEPTH` must be a power of two.

Top module: `vram_sam_ctrl`

## Requirements
- R1: With `xfer_n_i` low at the row strobe fall, `wen_n_i` high selects a read transfer. When the row strobe rises, every entry `i` of the register is loaded from `row_rdata_i[i*DW +: DW]` of the latched row, and the register enters output mode.
- R2: With `wen_n_i` low and `sen_n_i` high at the row strobe fall, the cycle is a write transfer. For the single cycle in which the row strobe rise is seen, `row_st_o` is asserted and `row_wdata_o` carries the register contents. The register then enters input mode.
- R3: With `wen_n_i` low and `sen_n_i` low at the row strobe fall, the cycle is a pseudo-transfer. `row_st_o` stays low, the register contents are unchanged, and the register enters input mode.
- R4: Every transfer loads the serial pointer with the column address latched at the row strobe fall. The first serial entry after a read transfer is the tap entry.
- R5: Each rising edge of `sclk_i` advances the pointer by one. Entry `DEPTH-1` is followed by entry 0.
- R6: In input mode, a rising edge of `sclk_i` with `sen_n_i` low writes `sdq_i` into the entry under the pointer. With `sen_n_i` high the write is ignored, but the pointer still advances.
- R7: `sdq_oe_o` is high only in output mode while `sen_n_i` is low. `sdq_o` shows the entry under the pointer.
- R8: A read transfer with `fsel_i` high at the row strobe fall enters split mode. In split mode `half_o` is 0 while the pointer is in the lower half and 1 while it is in the upper half, and it toggles as the pointer crosses the boundary.
- R9: Outside split mode, `half_o` takes the half containing the tap when the transfer completes. It holds that value while the pointer moves.
- R10: `wen_n_i`, `sen_n_i` and `fsel_i` matter only at the row strobe fall. Changing them while the row strobe is low has no effect on the transfer.
- R11: After reset the register is in input mode, the pointer is 0, `half_o` is 0, and no row store is requested.
- R12: A row strobe cycle with `xfer_n_i` high performs no transfer. There is no row store and the serial direction is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| xfer_n_i | input | 1 | Transfer gate, low marks a transfer cycle |
| wen_n_i | input | 1 | Write enable, active low |
| sen_n_i | input | 1 | Serial enable, active low |
| fsel_i | input | 1 | Special function select (split transfer) |
| row_addr_i | input | ROW_AW | Row address for the transfer |
| col_addr_i | input | AW | Column address, gives the tap |
| sclk_i | input | 1 | Serial clock |
| sdq_i | input | DW | Serial data in |
| sdq_o | output | DW | Serial data out |
| sdq_oe_o | output | 1 | Serial output enable |
| half_o | output | 1 | Half indicator |
| row_addr_o | output | ROW_AW | Latched row for the array interface |
| row_ld_o | output | 1 | Row load strobe (read transfer) |
| row_st_o | output | 1 | Row store strobe (write transfer) |
| row_wdata_o | output | DEPTH*DW | Register contents for a row store |
| row_rdata_i | input | DEPTH*DW | Row contents for a row load |

## Verification
The bench builds the block with `DEPTH` = 16, `DW` = 4 and `ROW_AW` = 2. With these values, pointer wrap and half-boundary crossings need only a few serial clocks. A full serial fill and a store can be compared against a four-row array model entry by entry. Pseudo-transfers and ignored serial writes are observed by storing the register back to a row and reading that row from the model.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  typedef enum logic [1:0] {
    XK_NONE   = 2'd0,
    XK_READ   = 2'd1,
    XK_WRITE  = 2'd2,
    XK_PSEUDO = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/vsc_rise.sv
module vsc_rise #(
  parameter logic INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sig_q <= INIT;
    else         sig_q <= sig_i;

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/vsc_xfer_dec.sv
module vsc_xfer_dec
  import vsc_pkg::*;
#(
  parameter int ROW_AW = 9,
  parameter int AW     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_fall_i,
  input  logic              ras_rise_i,
  input  logic              xfer_n_i,
  input  logic              wen_n_i,
  input  logic              sen_n_i,
  input  logic              fsel_i,
  input  logic [ROW_AW-1:0] row_i,
  input  logic [AW-1:0]     col_i,
  output logic              done_o,
  output xfer_kind_e        kind_o,
  output logic              split_o,
  output logic [ROW_AW-1:0] row_o,
  output logic [AW-1:0]     tap_o
);
  xfer_kind_e        kind_q;
  logic              split_q;
  logic [ROW_AW-1:0] row_q;
  logic [AW-1:0]     tap_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      kind_q  <= XK_NONE;
      split_q <= 1'b0;
      row_q   <= '0;
      tap_q   <= '0;
    end else if (ras_fall_i) begin
      // controls only count at the strobe fall
      if (xfer_n_i)     kind_q <= XK_NONE;
      else if (wen_n_i) kind_q <= XK_READ;
      else if (sen_n_i) kind_q <= XK_WRITE;
      else              kind_q <= XK_PSEUDO;
      split_q <= fsel_i;
      row_q   <= row_i;
      tap_q   <= col_i;
    end else if (ras_rise_i) begin
      kind_q <= XK_NONE;
    end

  assign done_o  = ras_rise_i && (kind_q != XK_NONE);
  assign kind_o  = kind_q;
  assign split_o = split_q;
  assign row_o   = row_q;
  assign tap_o   = tap_q;
endmodule

// File: rtl/vsc_sam.sv
module vsc_sam
  import vsc_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                done_i,
  input  xfer_kind_e          kind_i,
  input  logic                split_i,
  input  logic [AW-1:0]       tap_i,
  input  logic [DEPTH*DW-1:0] row_rdata_i,
  input  logic                sclk_rise_i,
  input  logic                sen_n_i,
  input  logic [DW-1:0]       sdq_i,
  output logic [DW-1:0]       sdq_o,
  output logic                sdq_oe_o,
  output logic                half_o,
  output logic [AW-1:0]       ptr_o,
  output logic                out_mode_o,
  output logic                split_mode_o,
  output logic                row_ld_o,
  output logic                row_st_o,
  output logic [DEPTH*DW-1:0] row_wdata_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q;
  logic          out_q, split_q, half_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ptr_q   <= '0;
      out_q   <= 1'b0;
      split_q <= 1'b0;
      half_q  <= 1'b0;
    end else if (done_i) begin
      ptr_q   <= tap_i;
      out_q   <= (kind_i == XK_READ);
      split_q <= (kind_i == XK_READ) && split_i;
      half_q  <= tap_i[AW-1];
      if (kind_i == XK_READ)
        for (int i = 0; i < DEPTH; i++) mem[i] <= row_rdata_i[i*DW +: DW];
    end else if (sclk_rise_i) begin
      ptr_q <= ptr_q + AW'(1);
      if (!out_q && !sen_n_i) mem[ptr_q] <= sdq_i;
    end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign row_wdata_o[g*DW +: DW] = mem[g];
  end

  assign sdq_o        = mem[ptr_q];
  assign sdq_oe_o     = out_q & ~sen_n_i;
  assign half_o       = split_q ? ptr_q[AW-1] : half_q;
  assign ptr_o        = ptr_q;
  assign out_mode_o   = out_q;
  assign split_mode_o = split_q;
  assign row_ld_o     = done_i && (kind_i == XK_READ);
  assign row_st_o     = done_i && (kind_i == XK_WRITE);
endmodule

// File: rtl/vram_sam_ctrl.sv
module vram_sam_ctrl
  import vsc_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DW     = 4,
  parameter int ROW_AW = 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ras_n_i,
  input  logic                xfer_n_i,
  input  logic                wen_n_i,
  input  logic                sen_n_i,
  input  logic                fsel_i,
  input  logic [ROW_AW-1:0]   row_addr_i,
  input  logic [AW-1:0]       col_addr_i,
  input  logic                sclk_i,
  input  logic [DW-1:0]       sdq_i,
  output logic [DW-1:0]       sdq_o,
  output logic                sdq_oe_o,
  output logic                half_o,
  output logic [ROW_AW-1:0]   row_addr_o,
  output logic                row_ld_o,
  output logic                row_st_o,
  output logic [DEPTH*DW-1:0] row_wdata_o,
  input  logic [DEPTH*DW-1:0] row_rdata_i
);
  logic          ras_fall, ras_rise, sclk_rise, done, split_sel;
  logic          out_mode, split_mode;
  xfer_kind_e    kind;
  logic [AW-1:0] tap, ptr;

  vsc_rise #(.INIT(1'b0)) u_ras_fall (
    .clk_i, .rst_ni, .sig_i(~ras_n_i), .rise_o(ras_fall));
  vsc_rise #(.INIT(1'b1)) u_ras_rise (
    .clk_i, .rst_ni, .sig_i(ras_n_i), .rise_o(ras_rise));
  vsc_rise #(.INIT(1'b0)) u_sclk (
    .clk_i, .rst_ni, .sig_i(sclk_i), .rise_o(sclk_rise));

  vsc_xfer_dec #(.ROW_AW(ROW_AW), .AW(AW)) u_dec (
    .clk_i, .rst_ni,
    .ras_fall_i(ras_fall), .ras_rise_i(ras_rise),
    .xfer_n_i, .wen_n_i, .sen_n_i, .fsel_i,
    .row_i(row_addr_i), .col_i(col_addr_i),
    .done_o(done), .kind_o(kind), .split_o(split_sel),
    .row_o(row_addr_o), .tap_o(tap));

  vsc_sam #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_sam (
    .clk_i, .rst_ni,
    .done_i(done), .kind_i(kind), .split_i(split_sel), .tap_i(tap),
    .row_rdata_i, .sclk_rise_i(sclk_rise), .sen_n_i, .sdq_i,
    .sdq_o, .sdq_oe_o, .half_o, .ptr_o(ptr),
    .out_mode_o(out_mode), .split_mode_o(split_mode),
    .row_ld_o, .row_st_o, .row_wdata_o);
endmodule

// File: rtl/vsc_chk.sv
module vsc_chk
  import vsc_pkg::*;
#(
  parameter int AW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done,
  input xfer_kind_e    kind,
  input logic [AW-1:0] tap,
  input logic [AW-1:0] ptr,
  input logic          sclk_rise,
  input logic          out_mode,
  input logic          split_mode,
  input logic          sen_n_i,
  input logic          sdq_oe_o,
  input logic          half_o,
  input logic          row_st_o
);
  // R1
  rd_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && kind == XK_READ |=> out_mode);
  // R2
  wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && kind == XK_WRITE |-> row_st_o);
  // R2
  wr_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && kind == XK_WRITE |=> !out_mode);
  // R3
  pseudo_nostore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && kind == XK_PSEUDO |-> !row_st_o);
  // R3
  pseudo_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && kind == XK_PSEUDO |=> !out_mode);
  // R4
  tap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> ptr == $past(tap));
  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise && !done |=> ptr == $past(ptr) + AW'(1));
  // R7
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_n_i |-> !sdq_oe_o);
  // R8
  split_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_mode |-> half_o == ptr[AW-1]);
  // R9
  half_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> split_mode || $stable(half_o));
endmodule

bind vram_sam_ctrl vsc_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done(done), .kind(kind), .tap(tap),
  .ptr(ptr), .sclk_rise(sclk_rise), .out_mode(out_mode),
  .split_mode(split_mode), .sen_n_i(sen_n_i), .sdq_oe_o(sdq_oe_o),
  .half_o(half_o), .row_st_o(row_st_o));

// File: tb/sim_vram_sam_ctrl.sv
module sim_vram_sam_ctrl;
  localparam int DEPTH  = 16;
  localparam int DW     = 4;
  localparam int ROW_AW = 2;
  localparam int AW     = $clog2(DEPTH);
  localparam int NROWS  = 1 << ROW_AW;

  logic clk = 0, rst_ni = 0;
  logic ras_n = 1, xfer_n = 1, wen_n = 1, sen_n = 1, fsel = 0, sclk = 0;
  logic [ROW_AW-1:0]   row_addr = '0;
  logic [AW-1:0]       col_addr = '0;
  logic [DW-1:0]       sdq_i = '0;
  logic [DW-1:0]       sdq_o;
  logic                sdq_oe, half, row_ld, row_st;
  logic [ROW_AW-1:0]   row_addr_o;
  logic [DEPTH*DW-1:0] row_wdata, row_rdata;

  logic [DEPTH*DW-1:0] bmem [NROWS];
  logic [DW-1:0]       reg_m [DEPTH];
  int                  ptr_m = 0;
  int                  st_cnt = 0;
  int                  vec = 0, bad = 0;
  bit                  fin = 0;
  logic [DW-1:0]       exp_q [$];
  event                mon_ev;

  always #5 clk = ~clk;

  vram_sam_ctrl #(.DEPTH(DEPTH), .DW(DW), .ROW_AW(ROW_AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ras_n_i(ras_n), .xfer_n_i(xfer_n),
    .wen_n_i(wen_n), .sen_n_i(sen_n), .fsel_i(fsel),
    .row_addr_i(row_addr), .col_addr_i(col_addr), .sclk_i(sclk),
    .sdq_i(sdq_i), .sdq_o(sdq_o), .sdq_oe_o(sdq_oe), .half_o(half),
    .row_addr_o(row_addr_o), .row_ld_o(row_ld), .row_st_o(row_st),
    .row_wdata_o(row_wdata), .row_rdata_i(row_rdata));

  assign row_rdata = bmem[row_addr_o];

  initial
    for (int r = 0; r < NROWS; r++)
      for (int i = 0; i < DEPTH; i++)
        bmem[r][i*DW +: DW] = DW'(r*5 + i*3 + 1);

  always @(posedge clk)
    if (row_st) begin
      bmem[row_addr_o] <= row_wdata;
      st_cnt <= st_cnt + 1;
    end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected serial data and compares
  always @(mon_ev) begin
    logic [DW-1:0] e;
    e = exp_q.pop_front();
    check(sdq_o === e && sdq_oe === 1'b1, "R4/R5 serial out", longint'(sdq_o), longint'(e));
  end

  function automatic logic [DEPTH*DW-1:0] flat_m();
    logic [DEPTH*DW-1:0] f;
    for (int i = 0; i < DEPTH; i++) f[i*DW +: DW] = reg_m[i];
    return f;
  endfunction

  // transfer cycle; controls may be changed while the strobe is low
  task automatic ras_cycle(input bit xn, input bit w, input bit s, input bit fs,
                           input int row, input int col,
                           input bit late, input bit lw, input bit lfs);
    xfer_n = xn; wen_n = w; sen_n = s; fsel = fs;
    row_addr = ROW_AW'(row); col_addr = AW'(col); ras_n = 0;
    @(negedge clk);
    if (late) begin wen_n = lw; fsel = lfs; end
    @(negedge clk);
    ras_n = 1;
    @(negedge clk);
    xfer_n = 1; wen_n = 1; fsel = 0;
  endtask

  task automatic model_read(input int row, input int tap);
    for (int i = 0; i < DEPTH; i++) reg_m[i] = bmem[row][i*DW +: DW];
    ptr_m = tap;
  endtask

  task automatic shift_out(input int n);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(reg_m[ptr_m]);
      -> mon_ev;
      #1;
      sclk = 1;
      @(negedge clk);
      sclk = 0;
      @(negedge clk);
      ptr_m = (ptr_m + 1) % DEPTH;
    end
  endtask

  task automatic shift_in(input logic [DW-1:0] v, input bit en);
    sdq_i = v; sen_n = !en; sclk = 1;
    @(negedge clk);
    sclk = 0;
    @(negedge clk);
    if (en) reg_m[ptr_m] = v;
    ptr_m = (ptr_m + 1) % DEPTH;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      bad++; vec++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    int st0;
    logic [DEPTH*DW-1:0] snap;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R11 reset state
    check(sdq_oe == 0, "R11 oe", sdq_oe, 0);
    check(half == 0, "R11 half", half, 0);
    check(row_st == 0, "R11 store", row_st, 0);
    for (int i = 0; i < DEPTH; i++) reg_m[i] = '0;
    ptr_m = 0;

    // R1 read transfer, tap 3, normal mode
    ras_cycle(0, 1, 0, 0, 1, 3, 0, 0, 0);
    sen_n = 0;
    model_read(1, 3);
    #1;
    check(sdq_oe == 1, "R1 output mode", sdq_oe, 1);
    check(half == 0, "R9 tap half", half, 0);
    shift_out(6);
    check(half == 0, "R9 half holds past boundary", half, 0);
    shift_out(10);  // R5 wraps past the last entry
    sen_n = 1;
    #1;
    check(sdq_oe == 0, "R7 oe gated", sdq_oe, 0);

    // R9 tap in the upper half
    ras_cycle(0, 1, 1, 0, 2, 12, 0, 0, 0);
    model_read(2, 12);
    check(half == 1, "R9 upper tap", half, 1);
    sen_n = 0;
    shift_out(5);  // R5 wrap 15 -> 0
    check(half == 1, "R9 half holds after wrap", half, 1);

    // R8 split mode
    ras_cycle(0, 1, 0, 1, 0, 6, 0, 0, 0);
    model_read(0, 6);
    check(half == 0, "R8 lower half", half, 0);
    shift_out(2);
    check(half == 1, "R8 crossed into upper", half, 1);
    shift_out(8);
    check(half == 0, "R8 wrapped to lower", half, 0);

    // R2 write transfer
    st0 = st_cnt;
    ras_cycle(0, 0, 1, 0, 3, 0, 0, 0, 0);
    ptr_m = 0;
    sen_n = 0;
    #1;
    check(st_cnt == st0 + 1, "R2 one store", st_cnt, st0 + 1);
    check(bmem[3] == flat_m(), "R2 stored row", bmem[3], flat_m());
    check(sdq_oe == 0, "R2 input mode", sdq_oe, 0);

    // R6 serial fill, entry 5 with serial enable off
    for (int k = 0; k < DEPTH; k++) shift_in(DW'(4'hF - k), k != 5);
    ras_cycle(0, 0, 1, 0, 1, 0, 0, 0, 0);
    ptr_m = 0;
    check(bmem[1] == flat_m(), "R6 serial fill stored", bmem[1], flat_m());

    // R3 pseudo-transfer
    ras_cycle(0, 1, 0, 0, 3, 2, 0, 0, 0);
    model_read(3, 2);
    sen_n = 0;
    #1;
    check(sdq_oe == 1, "R3 out before pseudo", sdq_oe, 1);
    st0 = st_cnt;
    snap = bmem[2];
    ras_cycle(0, 0, 0, 0, 2, 4, 0, 0, 0);
    ptr_m = 4;
    sen_n = 0;
    #1;
    check(st_cnt == st0, "R3 no store", st_cnt, st0);
    check(sdq_oe == 0, "R3 input mode", sdq_oe, 0);
    check(bmem[2] == snap, "R3 row untouched", bmem[2], snap);
    ras_cycle(0, 0, 1, 0, 0, 0, 0, 0, 0);
    ptr_m = 0;
    check(bmem[0] == flat_m(), "R3 register unchanged", bmem[0], flat_m());

    // R10 late control changes ignored
    ras_cycle(0, 1, 0, 0, 2, 7, 1, 0, 1);
    model_read(2, 7);
    sen_n = 0;
    #1;
    check(sdq_oe == 1, "R10 still read", sdq_oe, 1);
    shift_out(2);
    check(half == 0, "R10 not split", half, 0);

    // R12 non-transfer strobe cycle
    st0 = st_cnt;
    ras_cycle(1, 0, 1, 0, 1, 0, 0, 0, 0);
    sen_n = 0;
    #1;
    check(st_cnt == st0, "R12 no store", st_cnt, st0);
    check(sdq_oe == 1, "R12 direction kept", sdq_oe, 1);
    shift_out(3);

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule